// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block is the configuration register file of an IDE disk controller. The host reaches it through two I/O addresses. The index port sits at the base address. The data port sits four bytes above it. A host write to the index port selects a register. Later reads and writes on the data port then reach that register, for as long as the index is not rewritten.

The file holds the following registers:
- a read-only configuration byte that carries the silicon revision and an address-strap bit;
- a control byte that enables the secondary channel, sets fast device-select timing and disables read-ahead for the two primary drives;
- a command timing byte;
- address-setup and read/write timing bytes for the primary drives, and one shared pair for the secondary drives;
- a burst-size byte;
- a scratch byte, which software uses only to detect that the chip is present.

The register bits are driven straight out to the channel logic as decoded controls and timing fields. After reset every read-ahead is disabled, every timing is at its slowest and the secondary channel is off.

Top module: `cfg_index_port`

## Requirements
- R1: An I/O write to `BASE_ADDR` stores `io_wdata` as the register index. A following data-port access (`BASE_ADDR + 4`) reaches the register at that index. The index keeps its value until the index port is written again.
- R2: After reset the index is 0x00 and the registers hold these values:
  - 0x51 = 0xC0; 0x52 = 0x00;
  - 0x53 = 0xC0 and 0x55 = 0xC0; 0x54 = 0x00 and 0x56 = 0x00;
  - 0x57 = 0xCC; 0x58 = 0x00; 0x59 = 0x40; 0x5B = 0x00.
  
  The outputs therefore start as `ra_disable` = 4'hF, `sec_enable` = 0, `fast_devsel` = 0 and `burst_len` = 0x40.
- R3: Index 0x50 is read-only. It reads as `{2'b00, alt_base_strap, 3'b000, REV[1:0]}`, which is 0x22 with `REV` = 2 and the strap high. Writes to it change nothing.
- R4: In register 0x51:
  - bit 3 drives `sec_enable`;
  - bit 6 drives `ra_disable[0]`, the read-ahead disable for drive 0;
  - bit 7 drives `ra_disable[1]`, the read-ahead disable for drive 1.
- R5: `fast_devsel` is 1 whenever bit 0 or bit 1 of register 0x51 is 1, and 0 when both bits are 0.
- R6: In register 0x57:
  - bit 2 drives `ra_disable[2]`;
  - bit 3 drives `ra_disable[3]`;
  - bits 7:6 form the shared secondary setup field on `addr_setup[23:22]`.
- R7: Register 0x5B is a plain read/write byte. Any written value, 0xBD for example, reads back unchanged.
- R8: Registers 0x52 to 0x59 are read/write and appear on the outputs as follows:
  - 0x52 on `cmd_timing`;
  - 0x53, 0x55 and 0x57 on `addr_setup` bytes 0, 1 and 2;
  - 0x54, 0x56 and 0x58 on `rw_timing` bytes 0, 1 and 2;
  - 0x59 on `burst_len`.
- R9: A data-port read at an unmapped index returns 0x00. Unmapped means anything other than 0x50 to 0x59 and 0x5B. A data-port write at such an index changes no register.
- R10: `io_rdata` is combinational from a data-port read. It is 0x00 whenever no data-port read is in progress. Accesses to addresses other than the two ports change neither the index nor any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | AW | Host I/O address |
| io_wr | input | 1 | Host write strobe, one cycle |
| io_rd | input | 1 | Host read strobe |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Host read data |
| alt_base_strap | input | 1 | Board strap: alternate port base |
| sec_enable | output | 1 | Secondary channel enable |
| fast_devsel | output | 1 | Fast device-select host timing |
| ra_disable | output | 4 | Read-ahead disable, one bit per drive |
| cmd_timing | output | 8 | Command block timing byte |
| addr_setup | output | 24 | Address-setup bytes: drive 0, drive 1, shared secondary |
| rw_timing | output | 24 | Read/write timing bytes: drive 0, drive 1, shared secondary |
| burst_len | output | 8 | Read-ahead burst size byte |

## Verification
On every cycle the assertions check these properties:
- the configuration byte always reads with its revision and strap layout;
- unmapped indices and idle cycles always return zero;
- the index changes only on an index-port write;
- the control outputs and the secondary read-ahead bits change only on a data write to their own register.

Only the bench scenarios can show the remaining behaviour:
- the exact reset contents of each register;
- that a write lands in the register named by the index;
- the scratch byte read-back;
- the mapping of each register onto its output field;
- that accesses to neighbouring addresses are ignored.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

  localparam int NSLOT = 10;

  localparam logic [7:0] IDX_CFG  = 8'h50;
  localparam logic [7:0] IDX_CTRL = 8'h51;
  localparam logic [7:0] IDX_SEC  = 8'h57;

  // slot positions inside the writable file
  localparam int S_CTRL = 0;
  localparam int S_CMD  = 1;
  localparam int S_AS0  = 2;
  localparam int S_RW0  = 3;
  localparam int S_AS1  = 4;
  localparam int S_RW1  = 5;
  localparam int S_AS23 = 6;
  localparam int S_RW23 = 7;
  localparam int S_BRST = 8;
  localparam int S_SCR  = 9;

  localparam logic [7:0] SLOT_ADDR [NSLOT] = '{
    8'h51, 8'h52, 8'h53, 8'h54, 8'h55, 8'h56, 8'h57, 8'h58, 8'h59, 8'h5B
  };

  // slowest timings, read-ahead off, secondary off, burst 512 bytes
  localparam logic [7:0] SLOT_RST [NSLOT] = '{
    8'hC0, 8'h00, 8'hC0, 8'h00, 8'hC0, 8'h00, 8'hCC, 8'h00, 8'h40, 8'h00
  };

endpackage

// File: rtl/cfgport_host.sv
module cfgport_host #(
  parameter int              AW        = 16,
  parameter logic [AW-1:0]   BASE_ADDR = 16'h0178,
  parameter int              DATA_OFS  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] io_addr,
  input  logic          io_wr,
  input  logic          io_rd,
  input  logic [7:0]    io_wdata,
  output logic [7:0]    idx_q,
  output logic          data_we,
  output logic          data_re
);

  localparam logic [AW-1:0] DATA_ADDR = AW'(BASE_ADDR + AW'(DATA_OFS));

  logic idx_hit;
  logic idx_en;
  logic [7:0] idx_d;

  always_comb begin
    idx_hit = (io_addr == BASE_ADDR);
    idx_en  = io_wr && idx_hit;
    idx_d   = io_wdata;
    data_we = io_wr && (io_addr == DATA_ADDR);
    data_re = io_rd && (io_addr == DATA_ADDR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= 8'h00;
    else if (idx_en) idx_q <= idx_d;
  end

endmodule

// File: rtl/cfgport_regs.sv
module cfgport_regs
  import cfgport_pkg::*;
#(
  parameter int REV = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [7:0]             idx,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic [7:0]             wdata,
  input  logic                   alt_base_strap,
  output logic [7:0]             rdata,
  output logic [NSLOT-1:0][7:0]  slot_q
);

  localparam logic [1:0] REV2 = REV[1:0];

  logic [7:0] cfg_val;
  assign cfg_val = {2'b00, alt_base_strap, 3'b000, REV2};

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    logic       hit;
    logic [7:0] q;

    always_comb hit = wr_en && (idx == SLOT_ADDR[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= SLOT_RST[i];
      else if (hit) q <= wdata;
    end

    assign slot_q[i] = q;
  end

  always_comb begin
    rdata = 8'h00;
    if (rd_en) begin
      if (idx == IDX_CFG) rdata = cfg_val;
      for (int i = 0; i < NSLOT; i++) begin
        if (idx == SLOT_ADDR[i]) rdata = slot_q[i];
      end
    end
  end

endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port
  import cfgport_pkg::*;
#(
  parameter int            AW        = 16,
  parameter logic [AW-1:0] BASE_ADDR = 16'h0178,
  parameter int            REV       = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] io_addr,
  input  logic          io_wr,
  input  logic          io_rd,
  input  logic [7:0]    io_wdata,
  output logic [7:0]    io_rdata,
  input  logic          alt_base_strap,
  output logic          sec_enable,
  output logic          fast_devsel,
  output logic [3:0]    ra_disable,
  output logic [7:0]    cmd_timing,
  output logic [23:0]   addr_setup,
  output logic [23:0]   rw_timing,
  output logic [7:0]    burst_len
);

  localparam int DATA_OFS = 4;

  logic [7:0]            idx_q;
  logic                  data_we;
  logic                  data_re;
  logic [NSLOT-1:0][7:0] slot_q;

  cfgport_host #(
    .AW(AW), .BASE_ADDR(BASE_ADDR), .DATA_OFS(DATA_OFS)
  ) u_host (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
    .io_rd(io_rd), .io_wdata(io_wdata), .idx_q(idx_q),
    .data_we(data_we), .data_re(data_re)
  );

  cfgport_regs #(.REV(REV)) u_regs (
    .clk(clk), .rst_n(rst_n), .idx(idx_q), .wr_en(data_we),
    .rd_en(data_re), .wdata(io_wdata), .alt_base_strap(alt_base_strap),
    .rdata(io_rdata), .slot_q(slot_q)
  );

  always_comb begin
    sec_enable  = slot_q[S_CTRL][3];
    fast_devsel = slot_q[S_CTRL][0] | slot_q[S_CTRL][1];
    ra_disable  = {slot_q[S_AS23][3], slot_q[S_AS23][2],
                   slot_q[S_CTRL][7], slot_q[S_CTRL][6]};
    cmd_timing  = slot_q[S_CMD];
    addr_setup  = {slot_q[S_AS23], slot_q[S_AS1], slot_q[S_AS0]};
    rw_timing   = {slot_q[S_RW23], slot_q[S_RW1], slot_q[S_RW0]};
    burst_len   = slot_q[S_BRST];
  end

endmodule

// File: rtl/cfgport_chk.sv
module cfgport_chk #(
  parameter int            AW        = 16,
  parameter logic [AW-1:0] BASE_ADDR = 16'h0178,
  parameter int            REV       = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] io_addr,
  input logic          io_wr,
  input logic          io_rd,
  input logic [7:0]    io_rdata,
  input logic          alt_base_strap,
  input logic [7:0]    idx,
  input logic          sec_enable,
  input logic          fast_devsel,
  input logic [3:0]    ra_disable
);

  localparam logic [AW-1:0] DPORT = AW'(BASE_ADDR + AW'(4));
  localparam logic [1:0]    REV2  = REV[1:0];

  logic drd, dwr, iwr, mapped;
  always_comb begin
    drd    = io_rd && (io_addr == DPORT);
    dwr    = io_wr && (io_addr == DPORT);
    iwr    = io_wr && (io_addr == BASE_ADDR);
    mapped = ((idx >= 8'h50) && (idx <= 8'h59)) || (idx == 8'h5B);
  end

  // R1
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !iwr |=> $stable(idx));

  // R3
  cfg_layout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drd && idx == 8'h50) |-> io_rdata == {2'b00, alt_base_strap, 3'b000, REV2});

  // R9
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drd && !mapped) |-> io_rdata == 8'h00);

  // R10
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !drd |-> io_rdata == 8'h00);

  // R4
  ctrl_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dwr && idx == 8'h51) |=> $stable({sec_enable, fast_devsel, ra_disable[1:0]}));

  // R6
  sec_ra_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dwr && idx == 8'h57) |=> $stable(ra_disable[3:2]));

endmodule

bind cfg_index_port cfgport_chk #(.AW(AW), .BASE_ADDR(BASE_ADDR), .REV(REV)) u_chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
  .io_rdata(io_rdata), .alt_base_strap(alt_base_strap), .idx(idx_q),
  .sec_enable(sec_enable), .fast_devsel(fast_devsel), .ra_disable(ra_disable)
);

// File: tb/cfg_index_port_test.sv
module cfg_index_port_test;

  localparam logic [15:0] BASE = 16'h0178;
  localparam logic [15:0] DATA = 16'h017C;
  localparam logic [1:0]  K_IDX = 2'd0, K_WR = 2'd1, K_RD = 2'd2;
  localparam int NV = 23;
  // {kind, value, expected, requirement}
  localparam logic [21:0] VEC [NV] = '{
    {K_IDX, 8'h50, 8'h00, 4'd1},
    {K_RD,  8'h00, 8'h22, 4'd3},   // R3 revision + strap
    {K_WR,  8'hFF, 8'h00, 4'd3},
    {K_RD,  8'h00, 8'h22, 4'd3},   // R3 write ignored
    {K_IDX, 8'h51, 8'h00, 4'd1},
    {K_RD,  8'h00, 8'hC0, 4'd2},   // R2
    {K_WR,  8'h08, 8'h00, 4'd4},
    {K_RD,  8'h00, 8'h08, 4'd1},   // R1
    {K_IDX, 8'h5B, 8'h00, 4'd1},
    {K_RD,  8'h00, 8'h00, 4'd2},
    {K_WR,  8'hBD, 8'h00, 4'd7},
    {K_RD,  8'h00, 8'hBD, 4'd7},   // R7
    {K_IDX, 8'h59, 8'h00, 4'd1},
    {K_RD,  8'h00, 8'h40, 4'd2},
    {K_IDX, 8'h57, 8'h00, 4'd1},
    {K_RD,  8'h00, 8'hCC, 4'd2},
    {K_IDX, 8'h53, 8'h00, 4'd1},
    {K_RD,  8'h00, 8'hC0, 4'd2},
    {K_IDX, 8'h5A, 8'h00, 4'd1},
    {K_WR,  8'h77, 8'h00, 4'd9},
    {K_RD,  8'h00, 8'h00, 4'd9},   // R9
    {K_IDX, 8'h5B, 8'h00, 4'd1},
    {K_RD,  8'h00, 8'hBD, 4'd9}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic [15:0] io_addr;
  logic io_wr, io_rd;
  logic [7:0] io_wdata, io_rdata;
  logic alt_base_strap;
  logic sec_enable, fast_devsel;
  logic [3:0] ra_disable;
  logic [7:0] cmd_timing, burst_len;
  logic [23:0] addr_setup, rw_timing;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cfg_index_port uut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .alt_base_strap(alt_base_strap),
    .sec_enable(sec_enable), .fast_devsel(fast_devsel), .ra_disable(ra_disable),
    .cmd_timing(cmd_timing), .addr_setup(addr_setup), .rw_timing(rw_timing),
    .burst_len(burst_len)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
    #1;
  endtask

  task automatic io_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1 d = io_rdata;
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] idx, output logic [7:0] d);
    io_write(BASE, idx);
    io_read(DATA, d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    rst_n = 1'b0; io_addr = '0; io_wr = 0; io_rd = 0; io_wdata = '0;
    alt_base_strap = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R2 reset outputs
    check("R2 ra_disable", 32'(ra_disable), 32'hF);
    check("R2 sec_enable", 32'(sec_enable), 0);
    check("R2 fast_devsel", 32'(fast_devsel), 0);
    check("R2 burst_len", 32'(burst_len), 32'h40);
    check("R2 addr_setup", 32'(addr_setup), 32'hCCC0C0);
    check("R2 rw_timing", 32'(rw_timing), 0);
    check("R2 cmd_timing", 32'(cmd_timing), 0);

    for (int v = 0; v < NV; v++) begin
      logic [1:0] k;
      logic [7:0] val, exp;
      logic [3:0] rq;
      {k, val, exp, rq} = VEC[v];
      case (k)
        K_IDX: io_write(BASE, val);
        K_WR:  io_write(DATA, val);
        default: begin
          io_read(DATA, rd);
          nchk++;
          if (rd !== exp) begin
            nfail++;
            $display("FAIL R%0d vector %0d: actual %02h expected %02h", rq, v, rd, exp);
          end
        end
      endcase
    end

    // R4 ctrl = 0x08 from table
    check("R4 sec_enable", 32'(sec_enable), 1);
    check("R4 ra_disable", 32'(ra_disable), 32'hC);
    io_write(BASE, 8'h51); io_write(DATA, 8'h48);
    check("R4 ra_disable drive0 only", 32'(ra_disable), 32'hD);

    // R5 fast device select
    io_write(DATA, 8'h01); check("R5 bit0", 32'(fast_devsel), 1);
    io_write(DATA, 8'h02); check("R5 bit1", 32'(fast_devsel), 1);
    io_write(DATA, 8'h00); check("R5 off", 32'(fast_devsel), 0);

    // R6 shared secondary register
    io_write(BASE, 8'h57); io_write(DATA, 8'h48);
    check("R6 ra_disable", 32'(ra_disable), 32'h8);
    check("R6 setup field", 32'(addr_setup[23:22]), 1);

    // R8 timing bytes
    io_write(BASE, 8'h54); io_write(DATA, 8'h35);
    io_write(BASE, 8'h56); io_write(DATA, 8'h9A);
    io_write(BASE, 8'h58); io_write(DATA, 8'h21);
    check("R8 rw_timing", 32'(rw_timing), 32'h219A35);
    io_write(BASE, 8'h52); io_write(DATA, 8'h11);
    check("R8 cmd_timing", 32'(cmd_timing), 32'h11);
    io_write(BASE, 8'h55); io_write(DATA, 8'h80);
    check("R8 addr_setup", 32'(addr_setup), 32'h4880C0);
    io_write(BASE, 8'h59); io_write(DATA, 8'h00);
    check("R8 burst_len", 32'(burst_len), 0);
    reg_read(8'h56, rd); check("R8 readback", 32'(rd), 32'h9A);

    // R9 unmapped writes leave outputs alone
    io_write(BASE, 8'h00); io_write(DATA, 8'hFF);
    io_read(DATA, rd); check("R9 read 0x00", 32'(rd), 0);
    io_write(BASE, 8'h4F); io_write(DATA, 8'hFF);
    check("R9 rw_timing kept", 32'(rw_timing), 32'h219A35);
    check("R9 ra_disable kept", 32'(ra_disable), 32'h8);

    // R10 neighbour addresses ignored
    io_write(BASE, 8'h5B); io_write(DATA, 8'hAA);
    io_write(BASE + 16'd2, 8'h51);
    io_write(BASE + 16'd8, 8'h11);
    io_read(DATA, rd); check("R10 index/scratch kept", 32'(rd), 32'hAA);
    io_read(BASE, rd); check("R10 non-data read", 32'(rd), 0);

    // R2 reset mid-run, then data write with reset index is ignored
    @(negedge clk); rst_n = 1'b0; #1;
    check("R2 ra_disable again", 32'(ra_disable), 32'hF);
    check("R2 rw_timing again", 32'(rw_timing), 0);
    @(negedge clk); rst_n = 1'b1;
    io_write(DATA, 8'hFF);
    check("R2 ctrl untouched", 32'({sec_enable, fast_devsel}), 0);
    reg_read(8'h5B, rd); check("R2 scratch reset", 32'(rd), 0);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule